// File: doc/BRIEF.md
# Quad Serial DAC Code Controller

This block is the digital control core of a four-channel serial-input DAC. A host shifts 16-bit command words over a three-wire port: serial clock, an active-low frame strobe and a data line. The block captures each word and decodes a two-bit channel address, a power-down flag, a load flag and a left-justified data field. It keeps two registers for each channel. The input register stages a new code. The DAC register holds the code that is presented to the analog string. This lets a host write several channels and then update them all in one step.

The serial pins are brought into the `clk_i` domain through a synchronizer chain, and their edges are detected there. `clk_i` must therefore run well above the serial clock. The resolution is set at elaboration to 8, 10 or 12 bits. The outputs are four parallel codes and one flag, which asks the analog side to switch every channel off and float its output.

Top module: `qdac_ctrl`

## Requirements
- R1: A word is accepted only when the frame strobe rises after exactly 16 falling serial-clock edges have been seen while it was low. Bits arrive most significant first, bit 15 first. Serial-clock edges seen while the strobe is high are ignored.
- R2: Bits 15:14 address the channel: 00 is channel 0, 01 is channel 1, 10 is channel 2 and 11 is channel 3. Channel n appears on `code_o[n*RES +: RES]`.
- R3: The data field is left-justified at bit 11 and spans bits 11 down to 12-RES. At 10 bits, frame bits 1:0 are ignored. At 8 bits, frame bits 3:0 are ignored.
- R4: Every accepted word writes its data into the input register of the addressed channel.
- R5: When bit 12 (load) is 1, all four DAC registers take their input register values in the same step, and the addressed channel takes the new data.
- R6: When bit 12 is 0, no DAC register changes, so `code_o` holds its value.
- R7: `pd_o` takes bit 13 of every accepted word, whichever channel the word addresses. A value of 1 means all channels are off with high-impedance outputs. A value of 0 means normal operation.
- R8: Entering or leaving power-down leaves the stored codes unchanged.
- R9: A frame with fewer or more than 16 edges, including one with no edges at all, changes no register and no output.
- R10: After reset, every input register and every DAC register is zero and `pd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock used to sample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sync_ni | input | 1 | Frame strobe, active low |
| din_i | input | 1 | Serial data, most significant bit first |
| code_o | output | 4*RES | DAC register codes, channel 0 in the low bits |
| pd_o | output | 1 | All channels powered down with high-impedance outputs |

## Verification
The bench drives the same stimulus into three instances built at 8, 10 and 12 bits and compares each against one shared model. This exposes a data slice taken from the wrong bit position, because that shows up as a wrong code at the narrower widths.

Staged writes followed by a load through a different channel exercise the copy path. A design that copied only the addressed channel, or that updated on every write, would show stale or early codes.

Frames with 15, 17 or zero edges are each followed by a compare. A counter that accepted any count of 16 or more would corrupt a register here.

Power-down is set through one channel and cleared through another. This catches a flag that only certain addresses can change, and it catches codes that are wiped on power-down.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NCH     = 4;
  localparam int FRAME_W = 16;
  localparam int FIELD_W = 12;

  typedef struct packed {
    logic [1:0]         addr;
    logic               pd;
    logic               ld;
    logic [FIELD_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/qdac_serial_rx.sv
module qdac_serial_rx
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sync_ni,
  input  logic               din_i,
  output logic               valid_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] sclk_sr, sync_sr, din_sr;
  logic sclk_s, sync_s, din_s, sclk_d, sync_d;
  logic sclk_fall, sync_rise;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sr <= '0;
      sync_sr <= '1;
      din_sr  <= '0;
      sclk_d  <= 1'b0;
      sync_d  <= 1'b1;
    end else begin
      sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk_i};
      sync_sr <= {sync_sr[SYNC_STAGES-2:0], sync_ni};
      din_sr  <= {din_sr[SYNC_STAGES-2:0], din_i};
      sclk_d  <= sclk_s;
      sync_d  <= sync_s;
    end
  end

  assign sclk_s    = sclk_sr[SYNC_STAGES-1];
  assign sync_s    = sync_sr[SYNC_STAGES-1];
  assign din_s     = din_sr[SYNC_STAGES-1];
  assign sclk_fall = sclk_d & ~sclk_s;
  assign sync_rise = ~sync_d & sync_s;

  // count saturates one past a full word so long frames are rejected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (sync_s) begin
      cnt_q <= '0;
    end else if (sclk_fall) begin
      shift_q <= {shift_q[FRAME_W-2:0], din_s};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = sync_rise && (cnt_q == CNT_OK);
  assign frame_o = shift_q;

  p_cnt_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> (cnt_q == '0));
  p_frame_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_fall && !sync_s) |=> $stable(shift_q));
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
  import qdac_pkg::*;
#(
  parameter int RES = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [NCH*RES-1:0] code_o,
  output logic               pd_o
);
  frame_t               frm;
  logic [RES-1:0]       data_w;
  logic [NCH-1:0][RES-1:0] in_q, dac_q;
  logic                 pd_q;

  assign frm    = frame_t'(frame_i);
  assign data_w = frm.data[FIELD_W-1 -: RES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      dac_q <= '0;
      pd_q  <= 1'b0;
    end else if (valid_i) begin
      in_q[frm.addr] <= data_w;
      pd_q           <= frm.pd;
      if (frm.ld) begin
        for (int i = 0; i < NCH; i++)
          dac_q[i] <= (2'(i) == frm.addr) ? data_w : in_q[i];
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign code_o[g*RES +: RES] = dac_q[g];
  end
  assign pd_o = pd_q;

  p_in_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> in_q[$past(frm.addr)] == $past(data_w));
  p_load_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && frm.ld) |=> dac_q[$past(frm.addr)] == $past(data_w));
  p_dac_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && frm.ld) |=> $stable(dac_q));
  p_pd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(pd_q));
  p_pd_keeps_codes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !frm.ld) |=> $stable(code_o));
endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int RES         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sync_ni,
  input  logic               din_i,
  output logic [NCH*RES-1:0] code_o,
  output logic               pd_o
);
  logic               valid_w;
  logic [FRAME_W-1:0] frame_w;

  initial begin
    assert (RES == 8 || RES == 10 || RES == 12);
    assert (SYNC_STAGES >= 2);
  end

  qdac_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_i),
    .sync_ni (sync_ni),
    .din_i   (din_i),
    .valid_o (valid_w),
    .frame_o (frame_w)
  );

  qdac_regbank #(.RES(RES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_w),
    .frame_i (frame_w),
    .code_o  (code_o),
    .pd_o    (pd_o)
  );
endmodule

// File: tb/tb_qdac_ctrl.sv
module tb_qdac_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0, sclk = 1'b0, sync_n = 1'b1, din = 1'b0;
  logic [31:0] code8;
  logic [39:0] code10;
  logic [47:0] code12;
  logic pd8, pd10, pd12;
  int checks = 0, errors = 0;
  logic [11:0] in_m [4];
  logic [11:0] dac_m [4];
  logic pd_m;

  always #10 clk = ~clk;

  qdac_ctrl #(.RES(8))  dut8  (.clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sync_ni(sync_n),
                               .din_i(din), .code_o(code8), .pd_o(pd8));
  qdac_ctrl #(.RES(10)) dut10 (.clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sync_ni(sync_n),
                               .din_i(din), .code_o(code10), .pd_o(pd10));
  qdac_ctrl #(.RES(12)) dut   (.clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sync_ni(sync_n),
                               .din_i(din), .code_o(code12), .pd_o(pd12));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      chk({tag, " ch", $sformatf("%0d", c), " res8"},  int'(code8[c*8 +: 8]),   int'(dac_m[c] >> 4));
      chk({tag, " ch", $sformatf("%0d", c), " res10"}, int'(code10[c*10 +: 10]), int'(dac_m[c] >> 2));
      chk({tag, " ch", $sformatf("%0d", c), " res12"}, int'(code12[c*12 +: 12]), int'(dac_m[c]));
    end
    chk({tag, " pd"}, int'({pd8, pd10, pd12}), pd_m ? 7 : 0);
  endtask

  // R1: shift nedges bits MSB first, data taken on the falling serial edge
  task automatic send(input logic [15:0] w, input int nedges);
    @(negedge clk); sync_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nedges; i++) begin
      din = (i < 16) ? w[15-i] : 1'b0;
      @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
      repeat (3) @(negedge clk);
    end
    sync_n = 1'b1;
    repeat (8) @(negedge clk);
    if (nedges == 16) begin
      in_m[w[15:14]] = w[11:0];
      pd_m = w[13];
      if (w[12]) for (int c = 0; c < 4; c++) dac_m[c] = in_m[c];
    end
  endtask

  function automatic logic [15:0] mk(input int a, input bit p, input bit l, input int d);
    return {a[1:0], p, l, d[11:0]};
  endfunction

  task automatic t_reset;
    check_all("R10 reset");
  endtask

  task automatic t_addr;
    for (int a = 0; a < 4; a++) send(mk(a, 0, 1, 'h111 * (a + 5)), 16);
    check_all("R2 R4 R5 address decode");
  endtask

  task automatic t_stage;
    send(mk(0, 0, 0, 'h3C5), 16);
    send(mk(2, 0, 0, 'hA5A), 16);
    check_all("R6 staged no update");
    send(mk(3, 0, 1, 'h0F0), 16);
    check_all("R4 R5 load copies all");
  endtask

  task automatic t_res;
    send(mk(1, 0, 1, 'hFFF), 16);
    check_all("R3 full field");
    send(mk(1, 0, 1, 'h00F), 16);
    check_all("R3 low bits ignored");
    send(mk(1, 0, 1, 'h803), 16);
    check_all("R3 msb aligned");
  endtask

  task automatic t_pd;
    send(mk(2, 1, 0, 'h777), 16);
    check_all("R7 R8 pd set via ch2");
    send(mk(0, 0, 0, 'h123), 16);
    check_all("R7 R8 pd clear via ch0");
    send(mk(1, 1, 1, 'h456), 16);
    check_all("R7 R8 pd with load");
    send(mk(3, 0, 1, 'h9AB), 16);
    check_all("R8 resume codes");
  endtask

  task automatic t_abort;
    send(mk(2, 1, 1, 'hDEF), 15);
    check_all("R9 short frame");
    send(mk(1, 1, 1, 'hBCD), 17);
    check_all("R9 long frame");
    send(mk(0, 1, 1, 'hEEE), 0);
    check_all("R9 empty frame");
    // R1: serial edges while the strobe is high must not reach the shifter
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      din = 1'b1; sclk = 1'b1; repeat (4) @(negedge clk);
      sclk = 1'b0; repeat (4) @(negedge clk);
    end
    send(mk(2, 0, 1, 'h5A3), 16);
    check_all("R1 idle edges ignored");
  endtask

  task automatic t_random;
    for (int n = 0; n < 48; n++) begin
      send(16'($urandom), 16);
      check_all("R1 R5 R6 R7 random");
    end
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin in_m[c] = '0; dac_m[c] = '0; end
    pd_m = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_addr();
    t_stage();
    t_res();
    t_pd();
    t_abort();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule